// File: doc/BRIEF.md
# UART Baud Tick Generator

This block produces the timing enables for one serial channel. Everything runs on the system clock. A selectable prescaler divides that clock by 1 or by 4. A 16-bit programmable divisor then divides the result further to form a one-cycle sample enable, `sample_tick`. The transmitter uses the same enable to shift bits and the receiver uses it to sample. A second enable, `bit_tick`, marks each data-bit boundary. It fires on every 16th or every 8th sample enable, as the oversampling mode selects. The block never gates a clock; both outputs are clock enables.

Software reaches four byte registers through a write-only port:

| Address | Content |
|---------|---------|
| 0 | Divisor low byte |
| 1 | Divisor high byte |
| 2 | Control register; bit 7 selects the prescale ratio |
| 3 | Oversampling register; bit 0 is the mode |

Until the first write to address 2, a hardware select pin chooses the prescale ratio. That first write hands control to the software bit for the rest of the time until the next reset. Divisor writes and mode writes never shorten a period that is already running.

Internally, a configuration state machine has two states:
- `CFG_PIN`: the pin selects the prescale ratio.
- `CFG_SOFT`: the control bit selects the prescale ratio.

Its only transition is `CFG_PIN -> CFG_SOFT`, taken on any write to address 2.

An oversampling state machine also has two states:
- `OS_X16`: 16 sample ticks per bit.
- `OS_X8`: 8 sample ticks per bit.

It takes `OS_X16 -> OS_X8` or `OS_X8 -> OS_X16` only in a cycle where `bit_tick` is asserted, and only if the mode bit requests the other ratio.

Top module: `baud_tick_gen`

## Requirements
- R1: The prescaler passes every clock (ratio 1) or one clock in four (ratio 4). A value of 1 selects ratio 4, whether it comes from the pin or from bit 7 of address 2. Under ratio 4, sample ticks are never in adjacent cycles.
- R2: After reset, the prescale ratio follows `clk_sel_pin`. After any write to address 2, bit 7 of that register selects the ratio, and changes on the pin have no effect until the next reset. The other bits of address 2 are ignored.
- R3: The divisor is {address 1, address 0}. Sample ticks are spaced prescale ratio × divisor clock cycles apart.
- R4: Reset loads divisor low = 0x01, divisor high = 0x00 and 16x mode. In the first cycle after reset, `sample_tick` is 1 and `bit_tick` is 0.
- R5: A divisor of 0 gives the same spacing as a divisor of 1.
- R6: Bit 0 of address 3 selects 16x (1) or 8x (0). `bit_tick` asserts on every 16th or 8th sample tick, and only in a cycle that also has `sample_tick`.
- R7: A divisor write does not change the period in progress. The new value applies from the next terminal count.
- R8: A mode write during a bit does not change that bit. The new ratio applies from the next bit boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel_pin | input | 1 | Prescale select pin: 1 selects divide by 4 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 low divisor, 1 high divisor, 2 control, 3 mode) |
| wr_data | input | BYTE_W | Write data |
| sample_tick | output | 1 | One-cycle oversampling enable |
| bit_tick | output | 1 | One-cycle bit-boundary enable |

## Verification
The bench rewrites the divisor partway through a long period. A design that reloads at once would produce a short, runt period instead of finishing the old one. It switches the mode three sample ticks into a bit. A design that changes the ratio immediately would cut that bit to 8 ticks. It moves the select pin after software has taken over the prescaler. A design that kept following the pin would change the spacing. It also checks a zero divisor, which a naive down-counter would turn into a 65536-cycle stall, and the first cycle after reset, where an off-by-one reset value delays the first tick.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam logic [1:0] ADR_DIV_LO = 2'd0;
    localparam logic [1:0] ADR_DIV_HI = 2'd1;
    localparam logic [1:0] ADR_CTRL   = 2'd2;
    localparam logic [1:0] ADR_MODE   = 2'd3;

    localparam int unsigned MODE_BIT = 0;

    typedef enum logic {
        CFG_PIN,
        CFG_SOFT
    } cfg_state_e;

    typedef enum logic {
        OS_X16,
        OS_X8
    } os_state_e;

endpackage

// File: rtl/baud_regs.sv
module baud_regs
    import baud_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clk_sel_pin,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [BYTE_W-1:0]     wr_data,
    output logic [2*BYTE_W-1:0]   divisor,
    output logic                  pre_div4,
    output logic                  os_wide_req
);

    localparam int unsigned CTRL_PRE_BIT = BYTE_W - 1;

    logic [BYTE_W-1:0] div_lo_q;
    logic [BYTE_W-1:0] div_hi_q;
    logic              soft_pre_q;
    logic              ctrl_wr;
    cfg_state_e        cfg_q;
    cfg_state_e        cfg_next;

    assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_lo_q    <= BYTE_W'(1);
            div_hi_q    <= '0;
            soft_pre_q  <= 1'b0;
            os_wide_req <= 1'b1;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_DIV_LO: div_lo_q    <= wr_data;
                ADR_DIV_HI: div_hi_q    <= wr_data;
                ADR_CTRL:   soft_pre_q  <= wr_data[CTRL_PRE_BIT];
                default:    os_wide_req <= wr_data[MODE_BIT];
            endcase
        end
    end

    // Configuration state register
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_PIN;
        end else begin
            cfg_q <= cfg_next;
        end
    end

    // Next state
    always_comb begin
        cfg_next = cfg_q;
        unique case (cfg_q)
            CFG_PIN:  if (ctrl_wr) cfg_next = CFG_SOFT;
            CFG_SOFT: cfg_next = CFG_SOFT;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (cfg_q)
            CFG_PIN:  pre_div4 = clk_sel_pin;
            CFG_SOFT: pre_div4 = soft_pre_q;
        endcase
    end

    assign divisor = {div_hi_q, div_lo_q};

endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
    parameter int unsigned PRE_RATIO = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic div_sel,
    output logic pre_en
);

    localparam int unsigned PC_W = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRE_RATIO - 1);

    logic [PC_W-1:0] pcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
        end else if (pcnt_q == PC_LAST) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + PC_W'(1);
        end
    end

    assign pre_en = div_sel ? (pcnt_q == '0) : 1'b1;

endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pre_en,
    input  logic [DIV_W-1:0] divisor,
    output logic             sample_tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] eff_div;

    // A zero divisor behaves as one
    assign eff_div = (divisor == '0) ? DIV_W'(1) : divisor;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (pre_en) begin
            if (cnt_q == '0) begin
                cnt_q <= eff_div - DIV_W'(1);
            end else begin
                cnt_q <= cnt_q - DIV_W'(1);
            end
        end
    end

    assign sample_tick = pre_en && (cnt_q == '0);

endmodule

// File: rtl/baud_bitcount.sv
module baud_bitcount
    import baud_pkg::*;
#(
    parameter int unsigned OS_HI = 16,
    parameter int unsigned OS_LO = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_tick,
    input  logic os_wide_req,
    output logic bit_tick
);

    localparam int unsigned BC_W = $clog2(OS_HI);
    localparam logic [BC_W-1:0] LAST_HI = BC_W'(OS_HI - 1);
    localparam logic [BC_W-1:0] LAST_LO = BC_W'(OS_LO - 1);

    os_state_e       os_q;
    os_state_e       os_next;
    logic [BC_W-1:0] bcnt_q;
    logic [BC_W-1:0] last;

    // Oversampling state register
    always_ff @(posedge clk) begin
        if (rst) begin
            os_q <= OS_X16;
        end else begin
            os_q <= os_next;
        end
    end

    // Transitions only on a bit boundary
    always_comb begin
        os_next = os_q;
        unique case (os_q)
            OS_X16: if (bit_tick && !os_wide_req) os_next = OS_X8;
            OS_X8:  if (bit_tick &&  os_wide_req) os_next = OS_X16;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (os_q)
            OS_X16: last = LAST_HI;
            OS_X8:  last = LAST_LO;
        endcase
        bit_tick = sample_tick && (bcnt_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt_q <= '0;
        end else if (bit_tick) begin
            bcnt_q <= '0;
        end else if (sample_tick) begin
            bcnt_q <= bcnt_q + BC_W'(1);
        end
    end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned PRE_RATIO = 4,
    parameter int unsigned OS_HI     = 16,
    parameter int unsigned OS_LO     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_sel_pin,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              sample_tick,
    output logic              bit_tick
);

    localparam int unsigned DIV_W = 2 * BYTE_W;

    logic [DIV_W-1:0] divisor;
    logic             pre_div4;
    logic             os_wide_req;
    logic             pre_en;

    baud_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .clk_sel_pin (clk_sel_pin),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .divisor     (divisor),
        .pre_div4    (pre_div4),
        .os_wide_req (os_wide_req)
    );

    baud_prescale #(.PRE_RATIO(PRE_RATIO)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .div_sel (pre_div4),
        .pre_en  (pre_en)
    );

    baud_divider #(.DIV_W(DIV_W)) u_div (
        .clk         (clk),
        .rst         (rst),
        .pre_en      (pre_en),
        .divisor     (divisor),
        .sample_tick (sample_tick)
    );

    baud_bitcount #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_bits (
        .clk         (clk),
        .rst         (rst),
        .sample_tick (sample_tick),
        .os_wide_req (os_wide_req),
        .bit_tick    (bit_tick)
    );

endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
    parameter int unsigned OS_HI = 16,
    parameter int unsigned OS_LO = 8
) (
    input logic clk,
    input logic rst,
    input logic sample_tick,
    input logic bit_tick,
    input logic pre_en,
    input logic pre_div4
);

    localparam int unsigned SC_W = $clog2(OS_HI) + 1;

    logic [SC_W-1:0] sc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_q <= '0;
        end else if (bit_tick) begin
            sc_q <= '0;
        end else if (sample_tick) begin
            sc_q <= sc_q + SC_W'(1);
        end
    end

    p_sample_on_pre_r1: assert property (@(posedge clk) disable iff (rst)
        sample_tick |-> pre_en);

    p_div4_gap_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(pre_div4 && sample_tick) && pre_div4) |-> !sample_tick);

    p_bit_on_sample_r6: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick);

    p_bit_single_r6: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick || sample_tick);

    p_bit_window_r8: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> (sc_q == SC_W'(OS_HI - 1) || sc_q == SC_W'(OS_LO - 1)));

    p_no_overrun_r6: assert property (@(posedge clk) disable iff (rst)
        (sample_tick && !bit_tick) |-> (sc_q < SC_W'(OS_HI - 1)));

endmodule

bind baud_tick_gen baud_tick_chk #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick),
    .pre_en      (pre_en),
    .pre_div4    (pre_div4)
);

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;

    localparam time CLK_P = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_sel_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sample_tick;
    logic       bit_tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    baud_tick_gen u0 (
        .clk         (clk),
        .rst         (rst),
        .clk_sel_pin (clk_sel_pin),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst = 1'b1;
        clk_sel_pin = pin;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sync_tick();
        while (!sample_tick) @(negedge clk);
    endtask

    // Cycles from the current tick to the next one
    task automatic next_gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sample_tick);
    endtask

    task automatic settled_gap(output int n);
        int junk;
        sync_tick();
        next_gap(junk);
        next_gap(n);
    endtask

    // Sample ticks in one full bit, counted after a bit boundary
    task automatic bit_gap(output int ns);
        while (!bit_tick) @(negedge clk);
        ns = 0;
        do begin
            @(negedge clk);
            if (sample_tick) ns++;
        end while (!bit_tick);
    endtask

    task automatic t_reset_defaults();
        int g;
        do_reset(1'b0);
        check(sample_tick == 1'b1, "R4 first sample_tick", int'(sample_tick), 1);
        check(bit_tick == 1'b0, "R4 first bit_tick", int'(bit_tick), 0);
        next_gap(g);
        check(g == 1, "R4 default divisor gap", g, 1);
        bit_gap(g);
        check(g == 16, "R4 default 16x", g, 16);
    endtask

    task automatic t_pin_prescale();
        int g;
        do_reset(1'b1);
        check(sample_tick == 1'b1, "R4 first tick with pin high", int'(sample_tick), 1);
        next_gap(g);
        check(g == 4, "R1 pin prescale 4", g, 4);
        bit_gap(g);
        check(g == 16, "R1 bit under prescale", g, 16);
    endtask

    task automatic t_soft_override();
        int g;
        do_reset(1'b1);
        wr(2'd2, 8'h7F);
        settled_gap(g);
        check(g == 1, "R2 soft bit clear overrides pin", g, 1);
        clk_sel_pin = 1'b0;
        @(negedge clk);
        clk_sel_pin = 1'b1;
        settled_gap(g);
        check(g == 1, "R2 pin ignored after override", g, 1);
        clk_sel_pin = 1'b0;
        wr(2'd2, 8'h80);
        settled_gap(g);
        check(g == 4, "R2 soft bit set with pin low", g, 4);
    endtask

    task automatic t_divisor();
        int g;
        do_reset(1'b0);
        wr(2'd0, 8'h0C);
        settled_gap(g);
        check(g == 12, "R3 divisor 12", g, 12);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h00);
        settled_gap(g);
        check(g == 256, "R3 divisor 256 via high byte", g, 256);
        wr(2'd2, 8'h80);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h03);
        settled_gap(g);
        check(g == 12, "R3 prescale 4 times divisor 3", g, 12);
        bit_gap(g);
        check(g == 16, "R3 bit count at divisor 3", g, 16);
    endtask

    task automatic t_zero_div();
        int g;
        do_reset(1'b0);
        wr(2'd0, 8'h00);
        settled_gap(g);
        check(g == 1, "R5 zero divisor prescale 1", g, 1);
        wr(2'd2, 8'h80);
        settled_gap(g);
        check(g == 4, "R5 zero divisor prescale 4", g, 4);
    endtask

    task automatic t_mode8();
        int g;
        int cyc;
        do_reset(1'b0);
        wr(2'd0, 8'h02);
        wr(2'd3, 8'h00);
        bit_gap(g);
        bit_gap(g);
        check(g == 8, "R6 8x sample ticks per bit", g, 8);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!bit_tick);
        check(cyc == 16, "R6 8x bit period cycles", cyc, 16);
        wr(2'd3, 8'h01);
        bit_gap(g);
        bit_gap(g);
        check(g == 16, "R6 back to 16x", g, 16);
    endtask

    task automatic t_no_runt();
        int n;
        int g;
        do_reset(1'b0);
        wr(2'd0, 8'd100);
        sync_tick();
        next_gap(g);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 10) begin
                wr_en = 1'b1;
                wr_addr = 2'd0;
                wr_data = 8'd5;
            end else begin
                wr_en = 1'b0;
            end
        end while (!sample_tick);
        wr_en = 1'b0;
        check(n == 100, "R7 period in progress keeps old divisor", n, 100);
        next_gap(g);
        check(g == 5, "R7 new divisor after terminal", g, 5);
    endtask

    task automatic t_mode_boundary();
        int ns;
        do_reset(1'b0);
        wr(2'd0, 8'h04);
        while (!bit_tick) @(negedge clk);
        ns = 0;
        do begin
            @(negedge clk);
            wr_en = 1'b0;
            if (sample_tick && !bit_tick) begin
                ns++;
                if (ns == 3) begin
                    wr_en = 1'b1;
                    wr_addr = 2'd3;
                    wr_data = 8'h00;
                end
            end else if (sample_tick) begin
                ns++;
            end
        end while (!bit_tick);
        wr_en = 1'b0;
        check(ns == 16, "R8 current bit keeps 16x", ns, 16);
        ns = 0;
        do begin
            @(negedge clk);
            if (sample_tick) ns++;
        end while (!bit_tick);
        check(ns == 8, "R8 next bit uses 8x", ns, 8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_defaults();
        t_pin_prescale();
        t_soft_override();
        t_divisor();
        t_zero_div();
        t_mode8();
        t_no_runt();
        t_mode_boundary();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule